// File: doc/BRIEF.md
# I2C Bus Condition Detector with Spike Filter

This block sits behind the pads of an I2C client or host. It takes the raw, asynchronous SCL and SDA lines and brings each through a synchronizer into the system clock domain. A per-line filter then passes a new level on only after that level has held for a programmable number of consecutive clock cycles. Spikes on either wire are therefore removed before any bus condition is decoded. A noise pulse on SDA while SCL is high cannot turn into a false Start or Stop.

From the two clean levels the block produces single-cycle strobes for the rising and falling edges of SCL. It also produces single-cycle Start and Stop pulses and a bus-busy flag. The flag is raised by a Start and dropped by a Stop. The block has no knowledge of bytes, acknowledges or addresses; a protocol engine built on top consumes its outputs.

Top module: `i2c_cond_detect`

## Requirements
- R1: While reset is asserted and right after it is released, `scl_o` and `sda_o` are 1 (idle bus). `scl_rise_o`, `scl_fall_o`, `start_o`, `stop_o` and `busy_o` are 0. An active reset clears `busy_o` even in the middle of a transfer.
- R2: A line's clean level takes a new value only after the synchronized input has held that value for FILT_CYC consecutive cycles. A raw change driven before clock edge k appears on the clean output after edge k+SYNC_STAGES+FILT_CYC-1. A pulse held for FILT_CYC-1 cycles never reaches the output; a pulse held for exactly FILT_CYC cycles does.
- R3: `start_o` is high for exactly one cycle when clean SDA falls from 1 to 0 while clean SCL is 1 in both the current and the previous cycle.
- R4: `stop_o` is high for exactly one cycle when clean SDA rises from 0 to 1 while clean SCL is 1 in both the current and the previous cycle.
- R5: `scl_rise_o` is high for one cycle in the cycle in which clean SCL first reads 1 after reading 0. `scl_fall_o` is high for one cycle in the cycle in which clean SCL first reads 0 after reading 1. The two strobes are never high together.
- R6: `busy_o` becomes 1 in the cycle after a Start pulse. It becomes 0 in the cycle after a Stop pulse. Otherwise it holds its value.
- R7: When clean SCL and clean SDA change in the same cycle, neither `start_o` nor `stop_o` pulses, and `busy_o` is unchanged.
- R8: SDA changes while clean SCL is 0 produce no Start or Stop and leave `busy_o` unchanged.
- R9: An SDA spike shorter than FILT_CYC cycles while SCL is high produces no Start or Stop, and `sda_o` stays at its previous level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw | input | 1 | Raw serial clock line from the pad |
| sda_raw | input | 1 | Raw serial data line from the pad |
| scl_o | output | 1 | Filtered SCL level |
| sda_o | output | 1 | Filtered SDA level |
| scl_rise_o | output | 1 | One-cycle strobe on filtered SCL rising |
| scl_fall_o | output | 1 | One-cycle strobe on filtered SCL falling |
| start_o | output | 1 | One-cycle Start condition pulse |
| stop_o | output | 1 | One-cycle Stop condition pulse |
| busy_o | output | 1 | Bus busy flag, set by Start, cleared by Stop |

## Verification
The assertions assume that FILT_CYC is at least 1 and that SYNC_STAGES is at least 2. They also assume the raw lines are held at each level long enough for the filter to settle before the next change, except where a spike is deliberately injected. The stimulus drives both raw lines only at falling clock edges. Between table steps it holds every level for the full filter latency plus margin. Glitches are produced only by the directed tests, which set their widths to exactly FILT_CYC-1 or FILT_CYC cycles.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  // Counter width needed to count up to n.
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Edges from a raw change to the clean output change.
  function automatic int filt_latency(input int n, input int stages);
    return n + stages;
  endfunction

  // Line indices inside the two-bit line vectors.
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;

endpackage

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o
);
  localparam int CNT_W = i2c_cond_pkg::cnt_width(FILT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   level_q;
  logic                   synced;
  logic                   differs;
  logic                   accept;

  assign synced  = sync_q[SYNC_STAGES-1];
  assign differs = synced != level_q;
  assign accept  = differs && (cnt_q == CNT_LAST);
  assign level_o = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      cnt_q   <= '0;
      level_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      if (!differs) begin
        cnt_q <= '0;
      end else if (accept) begin
        cnt_q   <= '0;
        level_q <= synced;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // A new clean level must be the value the synchronizer presented.
  AST_LEVEL_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> (level_q == $past(synced))); // R2

  // The hold counter never runs past the filter window.
  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < FILT_CYC); // R2

  // An agreeing synchronizer output leaves the clean level alone.
  AST_HOLD_WHEN_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !differs |=> $stable(level_q)); // R2

endmodule

// File: rtl/bus_cond_decode.sv
module bus_cond_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic busy_o
);
  logic scl_q;
  logic sda_q;
  logic busy_q;
  logic scl_held_high;
  logic sda_fell;
  logic sda_rose;

  assign scl_held_high = scl_i && scl_q;
  assign sda_fell      = !sda_i && sda_q;
  assign sda_rose      = sda_i && !sda_q;

  assign scl_rise_o = scl_i && !scl_q;
  assign scl_fall_o = !scl_i && scl_q;
  assign start_o    = sda_fell && scl_held_high;
  assign stop_o     = sda_rose && scl_held_high;
  assign busy_o     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_o)     busy_q <= 1'b1;
      else if (stop_o) busy_q <= 1'b0;
    end
  end

  AST_START_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (scl_i && !sda_i && $past(sda_i))); // R3

  AST_STOP_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (scl_i && sda_i && !$past(sda_i))); // R4

  AST_SCL_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise_o, scl_fall_o})); // R5

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> busy_o); // R6

  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !busy_o); // R6

  AST_NO_COND_ON_SCL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise_o || scl_fall_o) |-> !(start_o || stop_o)); // R7

  AST_SCL_LOW_NO_COND: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_i |-> (!start_o && !stop_o)); // R8

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic busy_o
);
  import i2c_cond_pkg::*;

  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] raw_v;
  logic [NUM_LINES-1:0] clean_v;

  assign raw_v[LINE_SCL] = scl_raw;
  assign raw_v[LINE_SDA] = sda_raw;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    glitch_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_CYC    (FILT_CYC)
    ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (raw_v[g]),
      .level_o (clean_v[g])
    );
  end

  assign scl_o = clean_v[LINE_SCL];
  assign sda_o = clean_v[LINE_SDA];

  bus_cond_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (clean_v[LINE_SCL]),
    .sda_i      (clean_v[LINE_SDA]),
    .scl_rise_o (scl_rise_o),
    .scl_fall_o (scl_fall_o),
    .start_o    (start_o),
    .stop_o     (stop_o),
    .busy_o     (busy_o)
  );

  // Start and Stop never coincide at the block's edge.
  AST_ONE_CONDITION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o})); // R3

  // The busy flag only moves on a decoded condition.
  AST_BUSY_MOVES_ON_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o != $past(busy_o)) |-> ($past(start_o) || $past(stop_o))); // R6

endmodule

// File: tb/test_i2c_cond_detect.sv
module test_i2c_cond_detect;
  localparam int N   = 4;
  localparam int S   = 2;
  localparam int LAT = N + S;     // negedges from drive to new clean level
  localparam int WIN = LAT + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_raw = 1'b1;
  logic sda_raw = 1'b1;
  logic scl_o, sda_o, scl_rise_o, scl_fall_o, start_o, stop_o, busy_o;

  always #4 clk = ~clk;

  i2c_cond_detect #(.SYNC_STAGES(S), .FILT_CYC(N)) i_i2c_cond_detect (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
    .scl_o(scl_o), .sda_o(sda_o), .scl_rise_o(scl_rise_o),
    .scl_fall_o(scl_fall_o), .start_o(start_o), .stop_o(stop_o),
    .busy_o(busy_o)
  );

  int total = 0;
  int bad = 0;
  int c_st, c_sp, c_ri, c_fa, c_sda_lo;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    c_st = 0; c_sp = 0; c_ri = 0; c_fa = 0; c_sda_lo = 0;
    repeat (n) begin
      @(negedge clk);
      c_st += int'(start_o);
      c_sp += int'(stop_o);
      c_ri += int'(scl_rise_o);
      c_fa += int'(scl_fall_o);
      c_sda_lo += int'(!sda_o);
    end
  endtask

  // {scl, sda, starts, stops, rises, falls, busy_after}
  localparam logic [6:0] VEC [12] = '{
    7'b1010001,  // Start from idle
    7'b0000011,  // SCL falls
    7'b0100001,  // SDA rises with SCL low
    7'b1100101,  // SCL rises
    7'b0100011,  // SCL falls
    7'b0000001,  // SDA falls with SCL low
    7'b1000101,  // SCL rises
    7'b1101000,  // Stop
    7'b1010001,  // Start
    7'b1101000,  // Stop right after
    7'b0000010,  // both fall together
    7'b1100100   // both rise together
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(scl_o && sda_o && !busy_o && !start_o && !stop_o && !scl_rise_o && !scl_fall_o,
        "R1 in reset", {scl_o, sda_o, busy_o}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_o && sda_o && !busy_o && !start_o && !stop_o && !scl_rise_o && !scl_fall_o,
        "R1 after reset", {scl_o, sda_o, busy_o}, 3'b110);

    for (int i = 0; i < 12; i++) begin
      string rc;
      logic [6:0] v;
      v = VEC[i];
      scl_raw = v[6];
      sda_raw = v[5];
      run(WIN);
      rc = (i == 10 || i == 11) ? "R7" : ((i == 2 || i == 5) ? "R8" : "R3");
      chk(c_st == int'(v[4]), rc, c_st, int'(v[4]));
      rc = (i == 10 || i == 11) ? "R7" : ((i == 2 || i == 5) ? "R8" : "R4");
      chk(c_sp == int'(v[3]), rc, c_sp, int'(v[3]));
      chk(c_ri == int'(v[2]), "R5 rise", c_ri, int'(v[2]));
      chk(c_fa == int'(v[1]), "R5 fall", c_fa, int'(v[1]));
      chk(busy_o == v[0], "R6 busy", busy_o, v[0]);
      chk(scl_o == v[6] && sda_o == v[5], "R2 levels", {scl_o, sda_o}, v[6:5]);
    end

    // R2: exact latency, observed on SCL
    scl_raw = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    chk(scl_o == 1'b1, "R2 early", scl_o, 1);
    @(negedge clk);
    chk(scl_o == 1'b0, "R2 on time", scl_o, 0);
    chk(scl_fall_o == 1'b1, "R5 fall strobe timing", scl_fall_o, 1);
    scl_raw = 1'b1;
    run(WIN);

    // R9: SDA spike of N-1 cycles with SCL high
    sda_raw = 1'b0;
    repeat (N - 1) @(negedge clk);
    sda_raw = 1'b1;
    run(WIN);
    chk(c_st == 0 && c_sp == 0, "R9 no condition", c_st + c_sp, 0);
    chk(c_sda_lo == 0, "R9 sda level", c_sda_lo, 0);
    chk(busy_o == 1'b0, "R9 busy", busy_o, 0);

    // R2: SDA pulse of exactly N cycles passes
    sda_raw = 1'b0;
    repeat (N) @(negedge clk);
    sda_raw = 1'b1;
    run(WIN);
    chk(c_st == 1, "R2 N-cycle pulse start", c_st, 1);
    chk(c_sp == 1, "R2 N-cycle pulse stop", c_sp, 1);
    chk(busy_o == 1'b0, "R6 busy after pair", busy_o, 0);

    // R2: SCL spike of N-1 cycles leaves no edge
    scl_raw = 1'b0;
    repeat (N - 1) @(negedge clk);
    scl_raw = 1'b1;
    run(WIN);
    chk(c_fa == 0 && c_ri == 0, "R2 scl spike", c_fa + c_ri, 0);

    // R1: reset during a transfer clears busy
    sda_raw = 1'b0;
    run(WIN);
    chk(busy_o == 1'b1, "R6 busy set", busy_o, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b0 && sda_o == 1'b1, "R1 mid-transfer reset", {busy_o, sda_o}, 2'b01);
    sda_raw = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    run(WIN);
    chk(c_st == 0 && busy_o == 1'b0, "R1 idle after reset", busy_o, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule